// File: doc/BRIEF.md
# Prescaled Match Timer Core

This block is a free-running up-counter with a programmable prescaler and seven match comparators. A divider turns the clock into a counting tick, and the main count advances once per tick. Each comparator holds a value. When the count equals that value and a tick is due, the comparator fires. On a firing it can do any mix of three things: raise a pending flag, send the count back to zero, or stop the timer. It is meant to be the time base of a pulse-width output stage. Comparator 0 usually sets the period, and the other comparators set edge positions.

Software reaches the block through a plain register strobe: a write enable, a 4-bit word address and write data. Read data is returned in the same cycle. The word addresses are:

| Address | Register |
|---|---|
| 0 | control |
| 1 | pending flags |
| 2 | prescale limit |
| 3 | prescale count (read-only) |
| 4 | main count (read-only) |
| 5 | match control |
| 8 to 14 | match value 0 to 6 |

Any other address reads as zero. The block also exports the following, for the output stage:
- the count
- one firing pulse per comparator
- all seven match values
- an enable bit for the output stage
- a level interrupt

Top module: `pmt_core`

## Requirements
- R1: After reset, every register reads 0, `count_o` is 0 and `irq_o` is 0.
- R2: While running, the prescale count steps 0,1,…,P and then returns to 0, where P is the prescale limit. The main count advances by one on the same edge that returns the prescale count to 0, which is once every P+1 clocks. If the prescale count is already at or above a newly written lower limit, it wraps on the next enabled clock.
- R3: While control bit 0 (run) is 0, neither the main count nor the prescale count changes.
- R4: While control bit 1 (clear) is set, both counts become 0 at the next rising edge and stay 0, whatever the run bit is.
- R5: The control register stores only bits 0, 1 and 3, and its other bits read as 0. Bit 3 drives `pwm_en_o`.
- R6: The match control register holds three bits for comparator x: bit 3x enables its flag, bit 3x+1 clears the count on a firing, and bit 3x+2 stops the timer on a firing. Bits 31:21 read as 0.
- R7: `match_pulse_o[x]` is high in exactly the cycles where a tick is due and the main count equals match value x.
- R8: A firing whose clear-on-match bit is set makes the main count 0 at that edge, instead of count+1. A period value N therefore gives a period of N+1 ticks.
- R9: A firing whose stop bit is set still lets the count take its normal step at that edge, and it also clears control bit 0. Counting stays halted until software sets bit 0 again.
- R10: Flag x is set on a firing of comparator x only if its flag-enable bit is 1. Flag bit 7 always reads 0. Writing 1 to a flag bit clears it. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: `irq_o` is high in every cycle in which any flag is pending.
- R12: A software write to the control register in the same cycle as a stop firing takes precedence, so the written run bit is kept.
- R13: `match_vals_o[32x+31:32x]` always equals match value x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| count_o | output | 32 | Current main count |
| match_pulse_o | output | 7 | Per-comparator firing pulse |
| match_vals_o | output | 224 | All match values; value x in bits [32x+31:32x] |
| pwm_en_o | output | 1 | Output-stage enable (control bit 3) |
| irq_o | output | 1 | Level interrupt, high while any flag is pending |

## Verification
The following outputs are combinational views of state, so they are due in the same cycle as the state they show:
- read data
- the firing pulses
- the interrupt
- the exported match values

A register write, a tick, a clear, a stop and a flag update all take effect one edge after the cycle in which they are presented. The bench drives each stimulus on a falling edge and samples every output one time unit later. It compares those samples with a cycle model kept in the bench, and advances the model exactly once per clock. Every expected value therefore refers to the same edge count as the design's registers.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int unsigned PMT_CNT_W      = 32;
  localparam int unsigned PMT_NUM_MATCH  = 7;
  localparam int unsigned PMT_FLAG_W     = 8;
  localparam int unsigned PMT_ADDR_W     = 4;
  localparam int unsigned ADR_MATCH_BASE = 8;

  localparam logic [PMT_ADDR_W-1:0] ADR_CTRL = 4'd0;
  localparam logic [PMT_ADDR_W-1:0] ADR_FLAG = 4'd1;
  localparam logic [PMT_ADDR_W-1:0] ADR_PRE  = 4'd2;
  localparam logic [PMT_ADDR_W-1:0] ADR_PCNT = 4'd3;
  localparam logic [PMT_ADDR_W-1:0] ADR_CNT  = 4'd4;
  localparam logic [PMT_ADDR_W-1:0] ADR_MCTL = 4'd5;

  typedef struct packed {
    logic pwm;
    logic clr;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] pc_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] pc_q, pc_d;
  logic             pc_en;

  always_comb begin
    tick_o = run_i && (pc_q >= limit_i);
    pc_en  = clr_i || run_i;
    pc_d   = pc_q;
    if (clr_i)       pc_d = '0;
    else if (tick_o) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (pc_o == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> (pc_o == $past(pc_o)));
endmodule

// File: rtl/pmt_match_bank.sv
module pmt_match_bank #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 7
) (
  input  logic [CNT_W-1:0]           count_i,
  input  logic                       tick_i,
  input  logic [NUM_MATCH*CNT_W-1:0] mvals_i,
  input  logic [3*NUM_MATCH-1:0]     mctl_i,
  output logic [NUM_MATCH-1:0]       hit_o,
  output logic [NUM_MATCH-1:0]       flag_set_o,
  output logic                       clear_any_o,
  output logic                       stop_any_o
);
  logic [NUM_MATCH-1:0] clr_sel;
  logic [NUM_MATCH-1:0] stop_sel;

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
    assign hit_o[g]      = tick_i && (count_i == mvals_i[g*CNT_W +: CNT_W]);
    assign flag_set_o[g] = hit_o[g] && mctl_i[3*g];
    assign clr_sel[g]    = hit_o[g] && mctl_i[3*g+1];
    assign stop_sel[g]   = hit_o[g] && mctl_i[3*g+2];
  end

  assign clear_any_o = |clr_sel;
  assign stop_any_o  = |stop_sel;
endmodule

// File: rtl/pmt_core.sv
module pmt_core
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W     = PMT_CNT_W,
  parameter int unsigned NUM_MATCH = PMT_NUM_MATCH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [PMT_ADDR_W-1:0]      reg_addr,
  input  logic [CNT_W-1:0]           reg_wdata,
  output logic [CNT_W-1:0]           reg_rdata,
  output logic [CNT_W-1:0]           count_o,
  output logic [NUM_MATCH-1:0]       match_pulse_o,
  output logic [NUM_MATCH*CNT_W-1:0] match_vals_o,
  output logic                       pwm_en_o,
  output logic                       irq_o
);
  localparam int unsigned MCTL_W = 3 * NUM_MATCH;

  ctrl_t                  ctrl_q, ctrl_d;
  logic [CNT_W-1:0]       pre_q, tc_q, tc_d, pc;
  logic [MCTL_W-1:0]      mctl_q;
  logic [PMT_FLAG_W-1:0]  flag_q, flag_d, flag_set_ext;
  logic [CNT_W-1:0]       mr_q [NUM_MATCH];
  logic [NUM_MATCH-1:0]   hit, flag_set, wr_mr;
  logic                   tick, clear_any, stop_any;
  logic                   wr_ctrl, wr_flag, wr_pre, wr_mctl, tc_en;

  assign wr_ctrl = reg_we && (reg_addr == ADR_CTRL);
  assign wr_flag = reg_we && (reg_addr == ADR_FLAG);
  assign wr_pre  = reg_we && (reg_addr == ADR_PRE);
  assign wr_mctl = reg_we && (reg_addr == ADR_MCTL);

  pmt_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (ctrl_q.run && !ctrl_q.clr),
    .clr_i   (ctrl_q.clr),
    .limit_i (pre_q),
    .pc_o    (pc),
    .tick_o  (tick)
  );

  pmt_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_bank (
    .count_i     (tc_q),
    .tick_i      (tick),
    .mvals_i     (match_vals_o),
    .mctl_i      (mctl_q),
    .hit_o       (hit),
    .flag_set_o  (flag_set),
    .clear_any_o (clear_any),
    .stop_any_o  (stop_any)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)       ctrl_d = '{pwm: reg_wdata[3], clr: reg_wdata[1], run: reg_wdata[0]};
    else if (stop_any) ctrl_d.run = 1'b0;

    tc_en = ctrl_q.clr || tick;
    tc_d  = tc_q;
    if (ctrl_q.clr)     tc_d = '0;
    else if (clear_any) tc_d = '0;
    else                tc_d = tc_q + 1'b1;

    flag_set_ext = '0;
    flag_set_ext[NUM_MATCH-1:0] = flag_set;
    flag_d = flag_q;
    if (wr_flag) flag_d = flag_d & ~reg_wdata[PMT_FLAG_W-1:0];
    flag_d = flag_d | flag_set_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      mctl_q <= '0;
      flag_q <= '0;
      tc_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      if (wr_pre)  pre_q  <= reg_wdata;
      if (wr_mctl) mctl_q <= reg_wdata[MCTL_W-1:0];
      if (tc_en)   tc_q   <= tc_d;
    end
  end

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_mr
    assign wr_mr[g] = reg_we && (reg_addr == PMT_ADDR_W'(ADR_MATCH_BASE + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mr_q[g] <= '0;
      else if (wr_mr[g]) mr_q[g] <= reg_wdata;
    end
    assign match_vals_o[g*CNT_W +: CNT_W] = mr_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL: reg_rdata[3:0] = {ctrl_q.pwm, 1'b0, ctrl_q.clr, ctrl_q.run};
      ADR_FLAG: reg_rdata[PMT_FLAG_W-1:0] = flag_q;
      ADR_PRE:  reg_rdata = pre_q;
      ADR_PCNT: reg_rdata = pc;
      ADR_CNT:  reg_rdata = tc_q;
      ADR_MCTL: reg_rdata[MCTL_W-1:0] = mctl_q;
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (reg_addr == PMT_ADDR_W'(ADR_MATCH_BASE + i)) reg_rdata = mr_q[i];
      end
    endcase
  end

  assign count_o       = tc_q;
  assign match_pulse_o = hit;
  assign pwm_en_o      = ctrl_q.pwm;
  assign irq_o         = |flag_q;

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.clr |=> (count_o == '0));

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ctrl_q.clr) |=> (count_o == $past(count_o)));

  // R8
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_any |=> (count_o == '0));

  // R9
  stop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && !wr_ctrl) |=> !ctrl_q.run);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|flag_set));
endmodule

// File: tb/pmt_core_tb.sv
module pmt_core_tb_top;
  localparam int NM = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata, count_o;
  logic [NM-1:0] match_pulse_o;
  logic [NM*32-1:0] match_vals_o;
  logic          pwm_en_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "R1";

  logic [31:0] m_ctrl, m_flags, m_pr, m_pc, m_tc, m_mcr;
  logic [31:0] m_mr [NM];

  always #5 clk = ~clk;

  pmt_core dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
    .match_pulse_o(match_pulse_o), .match_vals_o(match_vals_o),
    .pwm_en_o(pwm_en_o), .irq_o(irq_o)
  );

  function automatic bit m_tick();
    return m_ctrl[0] && !m_ctrl[1] && (m_pc >= m_pr);
  endfunction

  function automatic logic [NM-1:0] m_hits();
    logic [NM-1:0] h = '0;
    for (int x = 0; x < NM; x++) h[x] = m_tick() && (m_tc == m_mr[x]);
    return h;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return m_flags;
      4'd2: return m_pr;
      4'd3: return m_pc;
      4'd4: return m_tc;
      4'd5: return m_mcr;
      default: return (a >= 4'd8 && a <= 4'd14) ? m_mr[a-4'd8] : 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_ctrl = 0; m_flags = 0; m_pr = 0; m_pc = 0; m_tc = 0; m_mcr = 0;
    for (int x = 0; x < NM; x++) m_mr[x] = 0;
  endtask

  task automatic m_step(bit we, logic [3:0] a, logic [31:0] d);
    logic [NM-1:0] h = m_hits();
    bit tk = m_tick();
    bit clr_any = 1'b0, stop_any = 1'b0;
    logic [31:0] setm = 0;
    for (int x = 0; x < NM; x++) begin
      if (h[x] && m_mcr[3*x+1]) clr_any = 1'b1;
      if (h[x] && m_mcr[3*x+2]) stop_any = 1'b1;
      if (h[x] && m_mcr[3*x])   setm[x] = 1'b1;
    end
    if (m_ctrl[1]) begin m_pc = 0; m_tc = 0; end
    else if (m_ctrl[0]) begin
      m_pc = tk ? 32'd0 : m_pc + 1;
      if (tk) m_tc = clr_any ? 32'd0 : m_tc + 1;
    end
    if (we && a == 4'd0) m_ctrl = d & 32'hB;
    else if (stop_any) m_ctrl = m_ctrl & ~32'd1;
    if (we && a == 4'd1) m_flags = m_flags & ~(d & 32'hFF);
    m_flags = m_flags | setm;
    if (we && a == 4'd2) m_pr = d;
    if (we && a == 4'd5) m_mcr = d & 32'h1FFFFF;
    if (we && a >= 4'd8 && a <= 4'd14) m_mr[a-4'd8] = d;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, logic [3:0] a, logic [31:0] d);
    int k;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    #1;
    k = $urandom % NM;
    chk(phase, "count", count_o, m_tc);
    chk(phase, "rdata", reg_rdata, m_read(a));
    chk("R5", "pwm_en", {31'd0, pwm_en_o}, {31'd0, m_ctrl[3]});
    chk("R7", "pulse", {25'd0, match_pulse_o}, {25'd0, m_hits()});
    chk("R11", "irq", {31'd0, irq_o}, {31'd0, m_flags != 0});
    chk("R13", "match_vals", match_vals_o[k*32 +: 32], m_mr[k]);
    m_step(we, a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on every address
    phase = "R1";
    for (int a = 0; a < 16; a++) cyc(0, 4'(a), 0);
    // R5: only bits 0,1,3 of control are kept
    phase = "R5";
    cyc(1, 0, 32'hFFFF_FFFF); cyc(0, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    // R6: match control width
    phase = "R6";
    cyc(1, 5, 32'hFFFF_FFFF); cyc(0, 5, 0); cyc(1, 5, 0); cyc(0, 5, 0);
    // R2: prescale 2, then lower limit below current prescale count
    phase = "R2";
    cyc(1, 2, 2); cyc(1, 0, 1);
    for (int i = 0; i < 20; i++) cyc(0, (i % 2) ? 4'd3 : 4'd4, 0);
    cyc(1, 2, 5); cyc(0, 3, 0); cyc(0, 3, 0); cyc(0, 3, 0); cyc(0, 3, 0); cyc(1, 2, 1);
    for (int i = 0; i < 6; i++) cyc(0, 3, 0);
    // R3: stopped run bit freezes both counters
    phase = "R3";
    cyc(1, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, (i % 2) ? 4'd3 : 4'd4, 0);
    // R4: clear dominates run
    phase = "R4";
    cyc(1, 0, 3);
    for (int i = 0; i < 5; i++) cyc(0, (i % 2) ? 4'd3 : 4'd4, 0);
    // R8: period 5 -> 6 ticks
    phase = "R8";
    cyc(1, 2, 0); cyc(1, 8, 5); cyc(1, 5, 32'h2); cyc(1, 0, 1);
    for (int i = 0; i < 20; i++) cyc(0, 4, 0);
    // R10: flag enable, w1c, bit 7
    phase = "R10";
    cyc(1, 9, 2); cyc(1, 5, 32'h3);
    for (int i = 0; i < 15; i++) cyc(0, 1, 0);
    cyc(1, 1, 32'h81); cyc(0, 1, 0); cyc(1, 1, 32'hFF); cyc(0, 1, 0);
    // R9: stop on comparator 1
    phase = "R9";
    cyc(1, 0, 2); cyc(1, 9, 3); cyc(1, 5, 32'h28); cyc(1, 1, 32'hFF); cyc(1, 0, 1);
    for (int i = 0; i < 10; i++) cyc(0, (i % 2) ? 4'd0 : 4'd4, 0);
    cyc(1, 0, 1);
    for (int i = 0; i < 8; i++) cyc(0, 4, 0);
    // R12: control write in the stop cycle wins
    phase = "R12";
    cyc(1, 0, 2); cyc(1, 10, 4); cyc(1, 5, 32'h100); cyc(1, 0, 1);
    for (int i = 0; i < 12; i++) begin
      bit stop_now = 1'b0;
      logic [NM-1:0] h = m_hits();
      for (int x = 0; x < NM; x++) if (h[x] && m_mcr[3*x+2]) stop_now = 1'b1;
      if (stop_now) cyc(1, 0, 1); else cyc(0, 0, 0);
    end
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    // random mix, checked against the model
    phase = "R10";
    cyc(1, 0, 2); cyc(1, 5, 32'h2); cyc(1, 8, 20); cyc(1, 0, 1);
    for (int i = 0; i < 3000; i++) begin
      bit we = (($urandom % 6) == 0);
      int sel = $urandom % 10;
      logic [3:0] a = (sel < 7) ? 4'(8 + sel) : (sel == 7) ? 4'd0 : (sel == 8) ? 4'd5 : 4'd1;
      logic [31:0] d;
      if (($urandom % 5) == 0) a = 4'd2;
      case (a)
        4'd0: d = {28'd0, ($urandom % 3) != 0 ? 1'b1 : 1'b0, 1'b0,
                   ($urandom % 10) == 0 ? 1'b1 : 1'b0, ($urandom % 5) != 0 ? 1'b1 : 1'b0};
        4'd2: d = $urandom % 4;
        4'd5: d = $urandom | 32'h2;
        4'd1: d = $urandom;
        default: d = $urandom % 24;
      endcase
      if (!we) a = 4'($urandom % 16);
      cyc(we, a, d);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule